// File: doc/BRIEF.md
# Run-Time Configurable Asynchronous Serial Frame Engine

This block pairs an asynchronous serial transmitter with a matching receiver. A four-bit mode register sets the character format at run time: 7 or 8 data bits, parity on or off, even or odd parity, and one or two stop bits. The transmitter accepts a byte over a valid/ready handshake and sends it on an idle-high line. The frame is a low start bit, the data bits least significant first, an optional parity bit, and then the stop bits. Each bit lasts 16 periods of an external oversampling tick.

The receiver watches the incoming line on every tick. It takes a falling edge as a possible start bit and confirms the start at the start bit's midpoint. It then samples every later bit at its centre. Each byte it recovers comes out with a one-cycle valid pulse, together with a parity-error flag and a framing-error flag.

The transmitter and the receiver each copy the mode register when one of their frames begins. Software can therefore rewrite the mode at any time without corrupting a frame already in progress. Loading the register with `mode_ld` takes the value on `mode_in`. The bit positions are: bit 0 selects 7-bit characters, bit 1 enables parity, bit 2 selects odd parity, and bit 3 selects two stop bits.

Top module: `serial_frame_engine`

## Requirements
- R1: After reset, `txd` is high, `tx_ready` is high and `rx_valid` is low. The mode register holds 0, which means 8 data bits, no parity, even sense and one stop bit. Whenever the transmitter is idle, `txd` stays high.
- R2: A transmitted frame is one low start bit, then the data bits least significant first, then the optional parity bit, then the stop bits. Each bit lasts 16 ticks of `os_tick`.
- R3: With `mode_in[0]`=1 (7-bit mode), bit 7 of `tx_data` is not sent and the frame carries seven data bits. The receiver returns `rx_data[7]` as 0 in this mode.
- R4: With `mode_in[1]`=1, a parity bit follows the data bits. With `mode_in[2]`=0 it makes the number of ones in the data plus parity even. With `mode_in[2]`=1 it makes that number odd.
- R5: With `mode_in[1]`=0, no parity bit is sent, `mode_in[2]` has no effect, and `rx_perr` stays 0.
- R6: With `mode_in[3]`=0 the frame ends after one high stop bit. With `mode_in[3]`=1 it ends after two high stop bits. `tx_ready` returns high only after the last stop bit.
- R7: The mode is captured when a frame starts. A mode load during a frame leaves that frame's format unchanged and applies from the next frame.
- R8: A low pulse on `rxd` that is no longer low at the start bit's midpoint is discarded, and no byte is delivered.
- R9: For each valid frame received, `rx_valid` pulses high for exactly one clock cycle, with the recovered data on `rx_data`.
- R10: With parity enabled, `rx_perr` is 1 alongside the byte when the ones in the received data plus the received parity bit do not match the selected sense.
- R11: `rx_ferr` is 1 alongside the byte when the first stop bit is sampled low.
- R12: `tx_ready` drops in the cycle after a handshake is accepted (`tx_valid` and `tx_ready` both high) and stays low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Single-cycle strobe at 16 times the bit rate |
| mode_ld | input | 1 | Loads `mode_in` into the mode register |
| mode_in | input | 4 | Mode value: [0] 7-bit, [1] parity enable, [2] odd sense, [3] two stop bits |
| tx_valid | input | 1 | Transmit byte is offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter is idle and can accept a byte |
| txd | output | 1 | Serial output line, idle high |
| rxd | input | 1 | Serial input line, asynchronous |
| rx_valid | output | 1 | One-cycle pulse when a received byte is available |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Parity mismatch on the received byte |
| rx_ferr | output | 1 | First stop bit of the received byte was low |

## Verification
Several properties are checked on every cycle:
- The idle transmit line is high.
- A low start bit follows each accepted handshake, and the transmitter stays busy after that handshake.
- The receive strobe is a single-cycle pulse.
- Bit 7 of a 7-bit character is clear.
- The parity flag stays low when parity is off.

Other behaviour can only be shown by the bench's directed scenarios, because it depends on whole frame sequences rather than a single cycle:
- the exact bit order on the line and the parity values;
- the frame length set by the stop field;
- that the mode stays latched when it changes mid-frame;
- glitch rejection;
- the parity and framing error flags on deliberately corrupted frames.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int CHAR_W    = 8;
    localparam int MAX_FRAME = 12;
    localparam int LEN_W     = $clog2(MAX_FRAME + 1);

    // bit 0: seven-bit, bit 1: parity on, bit 2: odd sense, bit 3: two stops
    typedef struct packed {
        logic two_stop;
        logic odd_sense;
        logic par_on;
        logic seven_bit;
    } frame_mode_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    function automatic logic [CHAR_W-1:0] char_mask(
        input logic [CHAR_W-1:0] d,
        input frame_mode_t       m
    );
        return m.seven_bit ? {1'b0, d[CHAR_W-2:0]} : d;
    endfunction

    function automatic logic parity_of(
        input logic [CHAR_W-1:0] d,
        input frame_mode_t       m
    );
        return (^char_mask(d, m)) ^ m.odd_sense;
    endfunction

    function automatic logic [LEN_W-1:0] frame_bits(input frame_mode_t m);
        logic [LEN_W-1:0] n;
        n = LEN_W'(1 + CHAR_W + 1);
        if (m.seven_bit) n = n - LEN_W'(1);
        if (m.par_on)    n = n + LEN_W'(1);
        if (m.two_stop)  n = n + LEN_W'(1);
        return n;
    endfunction

    function automatic logic [MAX_FRAME-1:0] pack_frame(
        input logic [CHAR_W-1:0] d,
        input frame_mode_t       m
    );
        logic [MAX_FRAME-1:0] f;
        int                   pos;
        f   = '1;
        f[0] = 1'b0;
        pos = 1;
        for (int i = 0; i < CHAR_W; i++) begin
            if ((i < CHAR_W - 1) || !m.seven_bit) begin
                f[pos] = d[i];
                pos    = pos + 1;
            end
        end
        if (m.par_on) f[pos] = parity_of(d, m);
        return f;
    endfunction

endpackage

// File: rtl/sfe_tx.sv
module sfe_tx
    import sfe_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  frame_mode_t       mode,
    input  logic              tx_valid,
    input  logic [CHAR_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              txd
);
    localparam int CW = $clog2(OVS);

    logic [MAX_FRAME-1:0] shift_q;
    logic [LEN_W-1:0]     left_q;
    logic [CW-1:0]        tcnt_q;
    logic                 accept;

    assign tx_ready = (left_q == '0);
    assign txd      = shift_q[0];
    assign accept   = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '1;
            left_q  <= '0;
            tcnt_q  <= '0;
        end else if (accept) begin
            shift_q <= pack_frame(tx_data, mode);
            left_q  <= frame_bits(mode);
            tcnt_q  <= '0;
        end else if ((left_q != '0) && tick) begin
            if (tcnt_q == CW'(OVS - 1)) begin
                tcnt_q  <= '0;
                shift_q <= {1'b1, shift_q[MAX_FRAME-1:1]};
                left_q  <= left_q - LEN_W'(1);
            end else begin
                tcnt_q <= tcnt_q + CW'(1);
            end
        end
    end

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd); // R1
    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
        accept |=> !txd); // R2
    AST_TX_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !tx_ready); // R12

endmodule

// File: rtl/sfe_rx.sv
module sfe_rx
    import sfe_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  frame_mode_t       mode,
    input  logic              rxd,
    output logic              rx_valid,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;
    localparam int BW   = $clog2(CHAR_W);

    logic              sync1_q, sync2_q, prev_q;
    rx_state_e         state_q;
    logic [CW-1:0]     tcnt_q;
    logic [BW-1:0]     bit_q;
    logic [CHAR_W-1:0] shift_q;
    logic              par_q;
    frame_mode_t       mode_q;
    logic [CHAR_W-1:0] word;
    logic [BW-1:0]     last_bit;
    logic              centre;

    assign word     = mode_q.seven_bit ? {1'b0, shift_q[CHAR_W-1:1]} : shift_q;
    assign last_bit = mode_q.seven_bit ? BW'(CHAR_W - 2) : BW'(CHAR_W - 1);
    assign centre   = (tcnt_q == CW'(OVS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q  <= 1'b1;
            sync2_q  <= 1'b1;
            prev_q   <= 1'b1;
            state_q  <= RX_IDLE;
            tcnt_q   <= '0;
            bit_q    <= '0;
            shift_q  <= '0;
            par_q    <= 1'b0;
            mode_q   <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_perr  <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            sync1_q  <= rxd;
            sync2_q  <= sync1_q;
            rx_valid <= 1'b0;
            if (tick) begin
                prev_q <= sync2_q;
                unique case (state_q)
                    RX_IDLE: begin
                        if (prev_q && !sync2_q) begin
                            state_q <= RX_START;
                            tcnt_q  <= '0;
                            mode_q  <= mode;
                        end
                    end
                    RX_START: begin
                        if (tcnt_q == CW'(HALF - 1)) begin
                            tcnt_q  <= '0;
                            bit_q   <= '0;
                            state_q <= sync2_q ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt_q <= tcnt_q + CW'(1);
                        end
                    end
                    RX_DATA: begin
                        if (centre) begin
                            tcnt_q  <= '0;
                            shift_q <= {sync2_q, shift_q[CHAR_W-1:1]};
                            if (bit_q == last_bit) begin
                                bit_q   <= '0;
                                state_q <= mode_q.par_on ? RX_PAR : RX_STOP;
                            end else begin
                                bit_q <= bit_q + BW'(1);
                            end
                        end else begin
                            tcnt_q <= tcnt_q + CW'(1);
                        end
                    end
                    RX_PAR: begin
                        if (centre) begin
                            tcnt_q  <= '0;
                            par_q   <= sync2_q;
                            state_q <= RX_STOP;
                        end else begin
                            tcnt_q <= tcnt_q + CW'(1);
                        end
                    end
                    RX_STOP: begin
                        if (centre) begin
                            tcnt_q   <= '0;
                            state_q  <= RX_IDLE;
                            rx_valid <= 1'b1;
                            rx_data  <= word;
                            rx_ferr  <= !sync2_q;
                            rx_perr  <= mode_q.par_on &&
                                        ((^word) ^ par_q ^ mode_q.odd_sense);
                        end else begin
                            tcnt_q <= tcnt_q + CW'(1);
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R9
    AST_RX_SEVEN_MSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && mode_q.seven_bit) |-> !rx_data[CHAR_W-1]); // R3
    AST_RX_NO_PERR_UNCHECKED: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !mode_q.par_on) |-> !rx_perr); // R5

endmodule

// File: rtl/serial_frame_engine.sv
module serial_frame_engine
    import sfe_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  logic              mode_ld,
    input  logic [3:0]        mode_in,
    input  logic              tx_valid,
    input  logic [CHAR_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    output logic              rx_valid,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr
);
    frame_mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= '0;
        else if (mode_ld) mode_q <= frame_mode_t'(mode_in);
    end

    sfe_tx #(.OVS(OVS)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (os_tick),
        .mode     (mode_q),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .txd      (txd)
    );

    sfe_rx #(.OVS(OVS)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .tick     (os_tick),
        .mode     (mode_q),
        .rxd      (rxd),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_perr  (rx_perr),
        .rx_ferr  (rx_ferr)
    );

endmodule

// File: tb/serial_frame_engine_tb_top.sv
module serial_frame_engine_tb_top;

    localparam int BITC = 64; // 16 ticks, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick;
    logic [1:0] tdiv = '0;
    logic       mode_ld = 1'b0;
    logic [3:0] mode_in = '0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready, txd, rxd;
    logic       rx_valid, rx_perr, rx_ferr;
    logic [7:0] rx_data;
    logic       sel_inj = 1'b0;
    logic       drv = 1'b1;

    int checks = 0;
    int errors = 0;
    int rx_seen = 0;
    logic [7:0] got_data;
    logic       got_perr, got_ferr;
    bit         done = 1'b0;

    always #10 clk = ~clk;
    always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
    assign os_tick = (tdiv == 2'd3);
    assign rxd = sel_inj ? drv : txd;

    serial_frame_engine dut_i (
        .clk(clk), .rst(rst), .os_tick(os_tick), .mode_ld(mode_ld),
        .mode_in(mode_in), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_seen  <= rx_seen + 1;
            got_data <= rx_data;
            got_perr <= rx_perr;
            got_ferr <= rx_ferr;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk);
        mode_in = m;
        mode_ld = 1'b1;
        @(negedge clk);
        mode_ld = 1'b0;
    endtask

    // Expected line pattern derived from R2..R6
    task automatic exp_frame(input logic [7:0] d, input logic [3:0] m,
                             output logic [11:0] f, output int n);
        int nd;
        logic ones;
        f = '1;
        f[0] = 1'b0;
        n = 1;
        nd = m[0] ? 7 : 8;
        ones = 1'b0;
        for (int i = 0; i < nd; i++) begin
            f[n] = d[i];
            ones = ones ^ d[i];
            n++;
        end
        if (m[1]) begin
            f[n] = m[2] ? ~ones : ones;
            n++;
        end
        n = n + (m[3] ? 2 : 1);
    endtask

    task automatic tx_frame(input logic [7:0] d, input logic [3:0] m,
                            input bit chg, input logic [3:0] m2, input string req);
        logic [11:0] ef, got;
        logic [7:0]  erx;
        int n, base, guard;
        exp_frame(d, m, ef, n);
        erx = m[0] ? {1'b0, d[6:0]} : d;
        base = rx_seen;
        got = '1;
        @(negedge clk);
        tx_data = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R12 busy after accept", 32'(tx_ready), 0);
        guard = 0;
        while (txd !== 1'b0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (BITC / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            if (i == n - 1)
                chk(tx_ready == 1'b0, "R6 busy through last stop", 32'(tx_ready), 0);
            if (i == 0 && chg) begin
                mode_in = m2;
                mode_ld = 1'b1;
                @(negedge clk);
                mode_ld = 1'b0;
                repeat (BITC - 1) @(negedge clk);
            end else begin
                repeat (BITC) @(negedge clk);
            end
        end
        chk(got == ef, {req, " line bits"}, 32'(got), 32'(ef));
        chk(tx_ready && txd, "R6 R1 idle after frame", {tx_ready, txd}, 2'b11);
        chk(rx_seen == base + 1, "R9 one byte delivered", rx_seen - base, 1);
        chk(got_data == erx, {req, " R9 loopback data"}, 32'(got_data), 32'(erx));
        chk(!got_perr && !got_ferr, "R10 R11 no flags on clean frame",
            {got_perr, got_ferr}, 0);
    endtask

    task automatic rx_inject(input logic [11:0] f, input int n, input logic [7:0] ed,
                             input bit ep, input bit ef, input string req);
        int base;
        base = rx_seen;
        @(negedge clk);
        sel_inj = 1'b1;
        for (int i = 0; i < n; i++) begin
            drv = f[i];
            repeat (BITC) @(negedge clk);
        end
        drv = 1'b1;
        repeat (BITC) @(negedge clk);
        chk(rx_seen == base + 1, {req, " byte delivered"}, rx_seen - base, 1);
        chk(got_data == ed, {req, " data"}, 32'(got_data), 32'(ed));
        chk(got_perr == ep, {req, " parity flag"}, 32'(got_perr), 32'(ep));
        chk(got_ferr == ef, {req, " framing flag"}, 32'(got_ferr), 32'(ef));
        sel_inj = 1'b0;
    endtask

    task automatic test_reset;
        chk(txd == 1'b1, "R1 txd idle", 32'(txd), 1);
        chk(tx_ready == 1'b1, "R1 ready", 32'(tx_ready), 1);
        chk(rx_valid == 1'b0, "R1 rx_valid", 32'(rx_valid), 0);
    endtask

    task automatic test_glitch;
        int base;
        base = rx_seen;
        @(negedge clk);
        sel_inj = 1'b1;
        drv = 1'b0;
        repeat (8) @(negedge clk);
        drv = 1'b1;
        repeat (BITC * 12) @(negedge clk);
        chk(rx_seen == base, "R8 glitch discarded", rx_seen - base, 0);
        sel_inj = 1'b0;
    endtask

    task automatic test_errors;
        logic [11:0] f;
        int n;
        set_mode(4'b0010);                  // 8 bits, even parity, 1 stop
        exp_frame(8'h55, 4'b0010, f, n);
        f[9] = ~f[9];                       // corrupt parity bit
        rx_inject(f, n, 8'h55, 1'b1, 1'b0, "R10");
        set_mode(4'b0000);
        exp_frame(8'hC3, 4'b0000, f, n);
        f[9] = 1'b0;                        // stop bit low
        rx_inject(f, n, 8'hC3, 1'b0, 1'b1, "R11");
        set_mode(4'b0111);                  // 7 bits, odd parity, clean
        exp_frame(8'h6B, 4'b0111, f, n);
        rx_inject(f, n, 8'h6B, 1'b0, 1'b0, "R3 R4 rx 7O1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        tx_frame(8'hA5, 4'b0000, 1'b0, 4'b0000, "R1 R2 reset mode 8N1");
        set_mode(4'b0010);
        tx_frame(8'h3C, 4'b0010, 1'b0, 4'b0000, "R4 even parity");
        set_mode(4'b1110);
        tx_frame(8'h3D, 4'b1110, 1'b0, 4'b0000, "R4 R6 odd parity two stops");
        set_mode(4'b0101);
        tx_frame(8'h80, 4'b0101, 1'b0, 4'b0000, "R3 R5 seven bit no parity");
        set_mode(4'b0111);
        tx_frame(8'hFF, 4'b0111, 1'b0, 4'b0000, "R3 R4 seven bit odd");
        set_mode(4'b0000);
        tx_frame(8'h96, 4'b0000, 1'b1, 4'b1010, "R7 mode held mid-frame");
        tx_frame(8'h96, 4'b1010, 1'b0, 4'b0000, "R7 new mode next frame");
        test_glitch();
        test_errors();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule